// File: doc/BRIEF.md
# Single-Precision Round to Int32-Range Integral Value

This unit takes one IEEE-754 single-precision operand and a 2-bit rounding mode. It returns a single-precision word holding the operand rounded to a whole number. It also raises an inexact flag and an invalid flag. The result stays in floating-point format. It is never converted to a two's-complement pattern. The whole numbers it can return are limited to those that fit a signed 32-bit integer.

Operands that are infinite or NaN have no integer meaning, and neither do values whose rounded magnitude leaves the signed 32-bit range. For all of these the unit returns the float encoding of the most negative 32-bit integer and raises invalid. Every other nonzero operand is rounded by the selected mode. Inexact goes high when the rounded value differs numerically from the operand. There is one register stage, with a valid strobe on each side.

Top module: `fri32_round`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. A synchronous reset clears `out_valid` and both flags.
- R2: A zero operand (0x00000000 or 0x80000000) is returned unchanged in every mode, with both flags low.
- R3: Mode 2'b00 rounds to the nearest whole number. An exact half goes to the even neighbour.
- R4: Mode 2'b01 rounds toward +infinity, mode 2'b10 toward -infinity, and mode 2'b11 toward zero.
- R5: `out_inexact` is high exactly when a valid, non-invalid result differs numerically from the operand.
- R6: An infinite or NaN operand (exponent field all ones) returns 0xCF000000 with `out_invalid` high.
- R7: Any value of magnitude 2^31 or more returns 0xCF000000 with invalid high. The one exception is -2^31 itself (0xCF000000 in, 0xCF000000 out), which is in range and raises no flag.
- R8: Whenever `out_invalid` is high, `out_inexact` is low.
- R9: A nonzero result keeps the operand's sign. A negative operand that rounds to zero, subnormals included, yields 0x80000000. A subnormal may round to 1.0 (0x3F800000) or -1.0 (0xBF800000) under the directed modes.
- R10: An operand with biased exponent from 150 up to 157 is already whole. It passes through unchanged with no flag.
- R11: Every valid, non-invalid, nonzero result has a biased exponent from 127 to 158, so it is a whole number no larger than 2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 up, 10 down, 11 toward zero |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_res | output | 32 | Single-precision whole-number result |
| out_inexact | output | 1 | Result differs from the operand |
| out_invalid | output | 1 | Operand is infinite, NaN or out of int32 range |

## Verification
The checker's properties that use `$past` of the operand assume `in_valid` is low while reset is asserted. The bench holds `in_valid` low throughout reset. After reset, each operand is driven on a falling edge with its strobe for a single cycle. The strobe is then dropped, so every output sample belongs to exactly one operand. The rounding mode is also assumed stable while the strobe is high, and the bench changes it only together with the operand.

// File: rtl/fri_pkg.sv
package fri_pkg;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int INT_BITS = 32;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_UP        = 2'b01,
    RM_DOWN      = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;
endpackage

// File: rtl/fri_classify.sv
// Splits the operand into its category and the shift that isolates the
// integer part of the significand.
module fri_classify #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int INT_BITS = 32,
  localparam int SIG_W   = MAN_W + 1,
  localparam int SH_W    = $clog2(SIG_W + 1)
) (
  input  logic [EXP_W-1:0] ex,
  input  logic [MAN_W-1:0] man,
  input  logic             sgn,
  output logic             is_zero,
  output logic             is_special,
  output logic             is_huge,
  output logic             is_min_int,
  output logic             is_whole,
  output logic             is_tiny,
  output logic [SIG_W-1:0] sig,
  output logic [SH_W-1:0]  sh
);
  localparam int BIAS   = 2 ** (EXP_W - 1) - 1;
  localparam int EMAX   = 2 ** EXP_W - 1;
  localparam int E_LIM  = BIAS + INT_BITS - 1;
  localparam int E_FULL = BIAS + MAN_W;

  int e;

  always_comb begin
    e          = int'(ex);
    is_special = (e == EMAX);
    is_zero    = (e == 0) && (man == '0);
    is_huge    = (e >= E_LIM) && !is_special;
    is_min_int = sgn && (e == E_LIM) && (man == '0);
    is_whole   = (e >= E_FULL) && (e < E_LIM);
    is_tiny    = !is_zero && (e < BIAS - 1);
    sig        = {(e != 0), man};
    if ((e >= BIAS - 1) && (e < E_FULL))
      sh = SH_W'(E_FULL - e);
    else
      sh = '0;
  end
endmodule

// File: rtl/fri_round.sv
// Integer part, guard and sticky extraction, and the mode-driven increment.
module fri_round #(
  parameter int MAN_W  = 23,
  localparam int SIG_W = MAN_W + 1,
  localparam int SH_W  = $clog2(SIG_W + 1)
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SH_W-1:0]  sh,
  input  logic             tiny,
  input  logic             sgn,
  input  logic [1:0]       rmode,
  output logic [SIG_W-1:0] mag,
  output logic             inexact
);
  import fri_pkg::*;

  int               s;
  logic [SIG_W-1:0] ipart;
  logic [SIG_W-1:0] lowmask;
  logic             rbit;
  logic             sticky;
  logic             inc;

  always_comb begin
    s = int'(sh);
    if (tiny || s == 0) begin
      ipart   = '0;
      rbit    = 1'b0;
      sticky  = !tiny ? 1'b0 : 1'b1;
      lowmask = '0;
    end else begin
      ipart   = sig >> s;
      rbit    = |((sig >> (s - 1)) & SIG_W'(1));
      lowmask = (SIG_W'(1) << (s - 1)) - SIG_W'(1);
      sticky  = |(sig & lowmask);
    end
    inexact = rbit | sticky;
    case (rmode_e'(rmode))
      RM_NEAR_EVEN: inc = rbit & (sticky | ipart[0]);
      RM_UP:        inc = inexact & !sgn;
      RM_DOWN:      inc = inexact & sgn;
      default:      inc = 1'b0;
    endcase
    mag = ipart + SIG_W'(inc);
  end
endmodule

// File: rtl/fri_pack.sv
// Renormalises a rounded magnitude back into single-precision form.
module fri_pack #(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  localparam int SIG_W = MAN_W + 1,
  localparam int W     = 1 + EXP_W + MAN_W
) (
  input  logic [SIG_W-1:0] mag,
  input  logic             sgn,
  output logic [W-1:0]     word
);
  localparam int BIAS = 2 ** (EXP_W - 1) - 1;

  int p;

  always_comb begin
    p = 0;
    for (int i = 0; i < SIG_W; i++)
      if (mag[i]) p = i;
    if (mag == '0)
      word = {sgn, {(W-1){1'b0}}};
    else
      word = {sgn, EXP_W'(BIAS + p), MAN_W'(mag << (MAN_W - p))};
  end
endmodule

// File: rtl/fri32_round.sv
module fri32_round #(
  parameter int EXP_W    = fri_pkg::EXP_W,
  parameter int MAN_W    = fri_pkg::MAN_W,
  parameter int INT_BITS = fri_pkg::INT_BITS,
  localparam int W       = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_op,
  input  logic [1:0]   in_rmode,
  output logic         out_valid,
  output logic [W-1:0] out_res,
  output logic         out_inexact,
  output logic         out_invalid
);
  localparam int SIG_W = MAN_W + 1;
  localparam int SH_W  = $clog2(SIG_W + 1);
  localparam int BIAS  = 2 ** (EXP_W - 1) - 1;
  localparam logic [W-1:0] MIN_INT_WORD =
    {1'b1, EXP_W'(BIAS + INT_BITS - 1), {MAN_W{1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic             is_zero, is_special, is_huge, is_min_int, is_whole, is_tiny;
  logic [SIG_W-1:0] sig;
  logic [SH_W-1:0]  sh;
  logic [SIG_W-1:0] mag;
  logic             rnd_inexact;
  logic [W-1:0]     packed_word;
  logic [W-1:0]     nxt_res;
  logic             nxt_inexact;
  logic             nxt_invalid;

  assign {sgn, ex, man} = in_op;

  fri_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_BITS(INT_BITS)) u_class (
    .ex(ex), .man(man), .sgn(sgn),
    .is_zero(is_zero), .is_special(is_special), .is_huge(is_huge),
    .is_min_int(is_min_int), .is_whole(is_whole), .is_tiny(is_tiny),
    .sig(sig), .sh(sh)
  );

  fri_round #(.MAN_W(MAN_W)) u_round (
    .sig(sig), .sh(sh), .tiny(is_tiny), .sgn(sgn), .rmode(in_rmode),
    .mag(mag), .inexact(rnd_inexact)
  );

  fri_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
    .mag(mag), .sgn(sgn), .word(packed_word)
  );

  always_comb begin
    if (is_special || (is_huge && !is_min_int)) begin
      nxt_res     = MIN_INT_WORD;
      nxt_inexact = 1'b0;
      nxt_invalid = 1'b1;
    end else if (is_zero || is_whole || is_min_int) begin
      nxt_res     = in_op;
      nxt_inexact = 1'b0;
      nxt_invalid = 1'b0;
    end else begin
      nxt_res     = packed_word;
      nxt_inexact = rnd_inexact;
      nxt_invalid = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res     <= nxt_res;
        out_inexact <= nxt_inexact;
        out_invalid <= nxt_invalid;
      end
    end
  end
endmodule

// File: rtl/fri32_round_chk.sv
module fri32_round_chk #(
  parameter int W = 32,
  parameter logic [W-1:0] MIN_WORD = 32'hCF000000
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_op,
  input logic         out_valid,
  input logic [W-1:0] out_res,
  input logic         out_inexact,
  input logic         out_invalid
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_zero_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[W-2:0] == '0) |=>
      (out_res == $past(in_op) && !out_inexact && !out_invalid));
  assert_special_invalid_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && &in_op[30:23]) |=> (out_invalid && out_res == MIN_WORD));
  assert_min_int_exact_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == MIN_WORD) |=>
      (out_res == MIN_WORD && !out_invalid && !out_inexact));
  assert_no_mixed_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (!out_inexact && out_res == MIN_WORD));
  assert_sign_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(&in_op[30:23]) && in_op[30:23] < 8'd158) |=>
      (out_res[W-1] == $past(in_op[W-1])));
  assert_whole_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[30:23] >= 8'd150 && in_op[30:23] <= 8'd157) |=>
      (out_res == $past(in_op) && !out_inexact && !out_invalid));
  assert_integral_range_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_invalid && out_res[30:23] != 8'd0) |->
      (out_res[30:23] >= 8'd127 && out_res[30:23] <= 8'd158));
endmodule

bind fri32_round fri32_round_chk #(.W(32), .MIN_WORD(32'hCF000000)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .out_valid(out_valid), .out_res(out_res),
  .out_inexact(out_inexact), .out_invalid(out_invalid)
);

// File: tb/tb_fri32_round.sv
`timescale 1ns/1ps
module tb_fri32_round;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic [1:0]  in_rmode = 2'b00;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_inexact;
  logic        out_invalid;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fri32_round dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_res(out_res),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  task automatic vec(input logic [31:0] op, input logic [1:0] rm,
                     input logic [31:0] er, input logic ex_inx,
                     input logic ex_inv, input string tag);
    @(negedge clk);
    in_op = op; in_rmode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!(out_valid && out_res == er && out_inexact == ex_inx &&
          out_invalid == ex_inv)) begin
      errors++;
      $display("FAIL %s op=%h rm=%0d got vld=%b res=%h inx=%b inv=%b exp vld=1 res=%h inx=%b inv=%b",
               tag, op, rm, out_valid, out_res, out_inexact, out_invalid,
               er, ex_inx, ex_inv);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid || out_inexact || out_invalid) begin
      errors++;
      $display("FAIL R1 reset got vld=%b inx=%b inv=%b exp 0 0 0",
               out_valid, out_inexact, out_invalid);
    end
  endtask

  task automatic t_strobe;
    vec(32'h3F800000, 2'b00, 32'h3F800000, 1'b0, 1'b0, "R1");
    @(negedge clk);
    checks++;
    if (out_valid) begin
      errors++;
      $display("FAIL R1 idle got vld=%b exp vld=0", out_valid);
    end
  endtask

  task automatic t_zero;
    for (int m = 0; m < 4; m++) begin
      vec(32'h00000000, 2'(m), 32'h00000000, 1'b0, 1'b0, "R2");
      vec(32'h80000000, 2'(m), 32'h80000000, 1'b0, 1'b0, "R2");
    end
  endtask

  task automatic t_nearest;
    vec(32'h3FC00000, 2'b00, 32'h40000000, 1'b1, 1'b0, "R3");
    vec(32'h40200000, 2'b00, 32'h40000000, 1'b1, 1'b0, "R3");
    vec(32'h3F000000, 2'b00, 32'h00000000, 1'b1, 1'b0, "R3");
    vec(32'hBFC00000, 2'b00, 32'hC0000000, 1'b1, 1'b0, "R3");
    vec(32'h3F400000, 2'b00, 32'h3F800000, 1'b1, 1'b0, "R3");
    vec(32'h4AFFFFFF, 2'b00, 32'h4B000000, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_directed;
    vec(32'h3FC00000, 2'b01, 32'h40000000, 1'b1, 1'b0, "R4");
    vec(32'hBFC00000, 2'b01, 32'hBF800000, 1'b1, 1'b0, "R4");
    vec(32'h3E800000, 2'b01, 32'h3F800000, 1'b1, 1'b0, "R4");
    vec(32'h3FC00000, 2'b10, 32'h3F800000, 1'b1, 1'b0, "R4");
    vec(32'hBFC00000, 2'b10, 32'hC0000000, 1'b1, 1'b0, "R4");
    vec(32'h3E800000, 2'b10, 32'h00000000, 1'b1, 1'b0, "R4");
    vec(32'hBFC00000, 2'b11, 32'hBF800000, 1'b1, 1'b0, "R4");
    vec(32'h40300000, 2'b11, 32'h40000000, 1'b1, 1'b0, "R4");
    vec(32'h4AFFFFFF, 2'b11, 32'h4AFFFFFE, 1'b1, 1'b0, "R4");
  endtask

  task automatic t_exact;
    vec(32'h40400000, 2'b00, 32'h40400000, 1'b0, 1'b0, "R5");
    vec(32'hC0000000, 2'b01, 32'hC0000000, 1'b0, 1'b0, "R5");
    vec(32'h4AFFFFFE, 2'b10, 32'h4AFFFFFE, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_special;
    vec(32'h7F800000, 2'b00, 32'hCF000000, 1'b0, 1'b1, "R6");
    vec(32'hFF800000, 2'b01, 32'hCF000000, 1'b0, 1'b1, "R6");
    vec(32'h7FC00000, 2'b11, 32'hCF000000, 1'b0, 1'b1, "R6");
  endtask

  task automatic t_range;
    vec(32'h4F000000, 2'b00, 32'hCF000000, 1'b0, 1'b1, "R7");
    vec(32'hCF000000, 2'b00, 32'hCF000000, 1'b0, 1'b0, "R7");
    vec(32'hCF000001, 2'b11, 32'hCF000000, 1'b0, 1'b1, "R7");
    vec(32'h60AD78EC, 2'b10, 32'hCF000000, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_neg_zero;
    vec(32'hBE800000, 2'b01, 32'h80000000, 1'b1, 1'b0, "R9");
    vec(32'hBE800000, 2'b11, 32'h80000000, 1'b1, 1'b0, "R9");
    vec(32'h80000001, 2'b00, 32'h80000000, 1'b1, 1'b0, "R9");
    vec(32'h00000001, 2'b01, 32'h3F800000, 1'b1, 1'b0, "R9");
    vec(32'h80000001, 2'b10, 32'hBF800000, 1'b1, 1'b0, "R9");
  endtask

  task automatic t_whole;
    vec(32'h4B000000, 2'b01, 32'h4B000000, 1'b0, 1'b0, "R10");
    vec(32'h4B800001, 2'b10, 32'h4B800001, 1'b0, 1'b0, "R10");
    vec(32'h4EFFFFFF, 2'b00, 32'h4EFFFFFF, 1'b0, 1'b0, "R10");
    vec(32'hCEFFFFFF, 2'b11, 32'hCEFFFFFF, 1'b0, 1'b0, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_strobe();
    t_zero();
    t_nearest();
    t_directed();
    t_exact();
    t_special();
    t_range();
    t_neg_zero();
    t_whole();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule